// File: doc/BRIEF.md
# Oversampled Serial Receiver with Automatic Ready-to-Send

This block receives asynchronous serial words on a single line, timed by a clock enable that pulses sixteen times per bit. It waits idle for a falling edge, confirms the start bit at its midpoint, then samples each data bit, an optional parity bit and one or two stop bits at their midpoints. Data arrives least significant bit first. At the midpoint of the last stop bit it copies the assembled word into a receive buffer. In that same cycle it sets the ready flag and writes the overrun, framing and parity flags and their summary.

An active-low ready-to-send output tells the far end when a word may be sent. It is forced inactive while reception is disabled. It becomes active when reception is enabled, and it drops automatically once a start bit is confirmed. It becomes active again only when the consumer pulses the buffer-read strobe. Reading the buffer also clears the ready flag.

Top module: `serial_rx_flow`

## Requirements
- R1: While idle, the bit-timing counter does not run. A sampled low on `rxIn` at a `sampleTick` starts it. Every later bit is sampled on the 8th tick of its 16-tick period, and ticks are counted only when `sampleTick` is high.
- R2: While `rxEnable` is 0, `rtsN` is 1 from the next cycle on, `rxReady` and all error flags read 0, and any frame in progress is abandoned. After reset `rtsN` is 1, `rxData` is 0 and all flags are 0.
- R3: The cycle after `rxEnable` goes from 0 to 1, `rtsN` reads 0.
- R4: When a start bit is confirmed low at its midpoint, `rtsN` goes to 1 without any read.
- R5: If the start bit reads high at its midpoint, the receiver returns to idle and leaves `rtsN`, `rxReady` and the flags unchanged.
- R6: `cfgDataLen` selects the word length: 0 gives 7 bits, 1 or 3 gives 8 bits, and 2 gives 9 bits. Bits arrive LSB first, and `rxData` holds the word zero-extended to 9 bits.
- R7: At the midpoint of the final stop bit, the word is copied to `rxData` and `rxReady` becomes 1 in the next cycle.
- R8: A one-cycle `bufRead` pulse clears `rxReady` and drives `rtsN` to 0 in the next cycle.
- R9: If a word is copied while `rxReady` is still 1, `errOverrun` is written 1 and the new word replaces the old one. A copy made while `rxReady` is 0 writes `errOverrun` to 0.
- R10: If either configured stop bit (`cfgTwoStop` 1 selects two) samples low, `errFraming` is written 1 at the copy. Otherwise it is written 0.
- R11: With `cfgParityEn` set, a parity bit follows the data. `cfgParityOdd` 0 means the data ones plus the parity bit must be even, and 1 means odd. On a mismatch `errParity` is written 1. Without parity it is written 0.
- R12: `errSummary` always equals the OR of the three error flags. All flags change only in the copy cycle or when reception is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | 16x bit-rate clock enable |
| rxIn | input | 1 | Serial data line, idle high |
| rxEnable | input | 1 | Reception enable |
| cfgDataLen | input | 2 | Word length code (see R6) |
| cfgParityEn | input | 1 | Parity bit present |
| cfgParityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| cfgTwoStop | input | 1 | 1 selects two stop bits |
| bufRead | input | 1 | Buffer-read strobe, one cycle |
| rxData | output | 9 | Receive buffer, zero-extended |
| rxReady | output | 1 | Buffer holds an unread word |
| errOverrun | output | 1 | Overrun flag |
| errFraming | output | 1 | Framing-error flag |
| errParity | output | 1 | Parity-error flag |
| errSummary | output | 1 | OR of the error flags |
| rtsN | output | 1 | Active-low ready-to-send |

## Verification
The bench sends a start pulse that is too short to reach the midpoint. A design that takes that edge as a frame would lift `rtsN` and later deliver a spurious word. It lets two words land without a read, then reads and sends a third. A design with sticky or missing overrun logic would report the wrong `errOverrun` on one of the two copies. It corrupts only the second of two stop bits, and it corrupts parity in both even and odd modes across all three word lengths. A design that checks one stop bit only, inverts the parity sense, or misaligns 7- and 9-bit words returns wrong flags or data. It also drops `rxEnable` with flags set and then raises it again, which exposes any design that keeps stale flags or fails to turn `rtsN` back on.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int RX_MAX_BITS = 9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP1, ST_STOP2
  } rxPhase_e;

  typedef struct packed {
    logic startFrame;
    logic shiftBit;
    logic parityBit;
    logic stopBit;
    logic commit;
  } rxStrobe_t;

  function automatic logic [3:0] dataBitsOf(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd7;
      2'd2:    return 4'd9;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxIn,
  input  logic       rxEnable,
  input  logic [1:0] cfgDataLen,
  input  logic       cfgParityEn,
  input  logic       cfgTwoStop,
  output rxStrobe_t  strobes
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);

  rxPhase_e         phase;
  logic [CNT_W-1:0] tickCnt;
  logic [3:0]       bitIdx;
  logic             midTick;
  logic [3:0]       dataBits;

  assign dataBits = dataBitsOf(cfgDataLen);
  assign midTick  = sampleTick && (phase != ST_IDLE) && (tickCnt == MID_CNT);

  always_comb begin
    strobes = '0;
    if (midTick) begin
      case (phase)
        ST_START:  strobes.startFrame = !rxIn;
        ST_DATA:   strobes.shiftBit   = 1'b1;
        ST_PARITY: strobes.parityBit  = 1'b1;
        ST_STOP1: begin
          strobes.stopBit = 1'b1;
          strobes.commit  = !cfgTwoStop;
        end
        ST_STOP2: begin
          strobes.stopBit = 1'b1;
          strobes.commit  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (!rxEnable) begin
      phase   <= ST_IDLE;
      tickCnt <= '0;
    end else if (sampleTick) begin
      if (phase == ST_IDLE) begin
        tickCnt <= '0;
        if (!rxIn) phase <= ST_START;
      end else begin
        tickCnt <= (tickCnt == LAST_CNT) ? '0 : tickCnt + 1'b1;
        if (midTick) begin
          case (phase)
            ST_START: begin
              bitIdx <= '0;
              phase  <= rxIn ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
              bitIdx <= bitIdx + 1'b1;
              if (bitIdx == dataBits - 1'b1)
                phase <= cfgParityEn ? ST_PARITY : ST_STOP1;
            end
            ST_PARITY: phase <= ST_STOP1;
            ST_STOP1:  phase <= cfgTwoStop ? ST_STOP2 : ST_IDLE;
            default:   phase <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/serial_rx_dpath.sv
module serial_rx_dpath
  import serial_rx_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rxIn,
  input  logic                   rxEnable,
  input  logic [1:0]             cfgDataLen,
  input  logic                   cfgParityOdd,
  input  logic                   bufRead,
  input  rxStrobe_t              strobes,
  output logic [RX_MAX_BITS-1:0] rxData,
  output logic                   rxReady,
  output logic                   errOverrun,
  output logic                   errFraming,
  output logic                   errParity,
  output logic                   errSummary,
  output logic                   rtsN
);
  logic [RX_MAX_BITS-1:0] shiftReg;
  logic [RX_MAX_BITS-1:0] aligned;
  logic                   parAcc, parBad, stopBad, stopBadNow, overrunNow;
  logic                   rxEnPrev;

  assign aligned    = shiftReg >> (4'(RX_MAX_BITS) - dataBitsOf(cfgDataLen));
  assign stopBadNow = stopBad || (strobes.stopBit && !rxIn);
  assign overrunNow = rxReady && !bufRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBad   <= 1'b0;
      stopBad  <= 1'b0;
    end else if (strobes.startFrame) begin
      parAcc  <= 1'b0;
      parBad  <= 1'b0;
      stopBad <= 1'b0;
    end else if (strobes.shiftBit) begin
      shiftReg <= {rxIn, shiftReg[RX_MAX_BITS-1:1]};
      parAcc   <= parAcc ^ rxIn;
    end else if (strobes.parityBit) begin
      parBad <= parAcc ^ rxIn ^ cfgParityOdd;
    end else if (strobes.stopBit) begin
      stopBad <= stopBadNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxReady    <= 1'b0;
      errOverrun <= 1'b0;
      errFraming <= 1'b0;
      errParity  <= 1'b0;
      errSummary <= 1'b0;
    end else if (!rxEnable) begin
      rxReady    <= 1'b0;
      errOverrun <= 1'b0;
      errFraming <= 1'b0;
      errParity  <= 1'b0;
      errSummary <= 1'b0;
    end else if (strobes.commit) begin
      rxData     <= aligned;
      rxReady    <= 1'b1;
      errOverrun <= overrunNow;
      errFraming <= stopBadNow;
      errParity  <= parBad;
      errSummary <= overrunNow || stopBadNow || parBad;
    end else if (bufRead) begin
      rxReady <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEnPrev <= 1'b0;
      rtsN     <= 1'b1;
    end else begin
      rxEnPrev <= rxEnable;
      if (!rxEnable)              rtsN <= 1'b1;
      else if (!rxEnPrev)         rtsN <= 1'b0;
      else if (strobes.startFrame) rtsN <= 1'b1;
      else if (bufRead)           rtsN <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_flow.sv
module serial_rx_flow
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxIn,
  input  logic       rxEnable,
  input  logic [1:0] cfgDataLen,
  input  logic       cfgParityEn,
  input  logic       cfgParityOdd,
  input  logic       cfgTwoStop,
  input  logic       bufRead,
  output logic [8:0] rxData,
  output logic       rxReady,
  output logic       errOverrun,
  output logic       errFraming,
  output logic       errParity,
  output logic       errSummary,
  output logic       rtsN
);
  rxStrobe_t strobes;
  logic      commitPulse;
  logic      startPulse;

  assign commitPulse = strobes.commit;
  assign startPulse  = strobes.startFrame;

  serial_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxIn(rxIn),
    .rxEnable(rxEnable), .cfgDataLen(cfgDataLen), .cfgParityEn(cfgParityEn),
    .cfgTwoStop(cfgTwoStop), .strobes(strobes)
  );

  serial_rx_dpath dpath_i (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .rxEnable(rxEnable),
    .cfgDataLen(cfgDataLen), .cfgParityOdd(cfgParityOdd), .bufRead(bufRead),
    .strobes(strobes), .rxData(rxData), .rxReady(rxReady),
    .errOverrun(errOverrun), .errFraming(errFraming), .errParity(errParity),
    .errSummary(errSummary), .rtsN(rtsN)
  );
endmodule

// File: rtl/serial_rx_flow_chk.sv
module serial_rx_flow_chk (
  input logic clk,
  input logic rstN,
  input logic rxEnable,
  input logic bufRead,
  input logic rxReady,
  input logic errOverrun,
  input logic errFraming,
  input logic errParity,
  input logic errSummary,
  input logic rtsN,
  input logic commitPulse,
  input logic startPulse
);
  AST_RTS_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> rtsN); // R2
  AST_FLAGS_CLR_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (!rxReady && !errSummary)); // R2
  AST_RTS_ON_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxEnable) |=> !rtsN); // R3
  AST_RTS_OFF_START: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && rxEnable) |=> rtsN); // R4
  AST_READY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (commitPulse && rxEnable) |=> rxReady); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (bufRead && rxEnable && $past(rxEnable) && !commitPulse && !startPulse)
      |=> (!rxReady && !rtsN)); // R8
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (commitPulse && rxEnable && rxReady && !bufRead) |=> errOverrun); // R9
  AST_SUMMARY_OR: assert property (@(posedge clk) disable iff (!rstN)
    errSummary == (errOverrun || errFraming || errParity)); // R12
  AST_FLAGS_ATOMIC: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && $past(rxEnable) && !$stable(errFraming)) |-> $past(commitPulse)); // R12
endmodule

bind serial_rx_flow serial_rx_flow_chk chk_i (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .bufRead(bufRead),
  .rxReady(rxReady), .errOverrun(errOverrun), .errFraming(errFraming),
  .errParity(errParity), .errSummary(errSummary), .rtsN(rtsN),
  .commitPulse(commitPulse), .startPulse(startPulse)
);

// File: tb/serial_rx_flow_tb_top.sv
module serial_rx_flow_tb_top;
  localparam int TICK_DIV = 2;
  localparam int BIT_CLK  = 16 * TICK_DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0;
  logic rxIn = 1'b1;
  logic rxEnable = 1'b0;
  logic [1:0] cfgDataLen = 2'd1;
  logic cfgParityEn = 1'b0, cfgParityOdd = 1'b0, cfgTwoStop = 1'b0;
  logic bufRead = 1'b0;
  logic [8:0] rxData;
  logic rxReady, errOverrun, errFraming, errParity, errSummary, rtsN;

  int checks = 0;
  int failures = 0;
  bit expReady = 1'b0;
  int tickPhase = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tickPhase  = (tickPhase + 1) % TICK_DIV;
    sampleTick = (tickPhase == 0);
  end

  serial_rx_flow dut_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxIn(rxIn),
    .rxEnable(rxEnable), .cfgDataLen(cfgDataLen), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .cfgTwoStop(cfgTwoStop), .bufRead(bufRead),
    .rxData(rxData), .rxReady(rxReady), .errOverrun(errOverrun),
    .errFraming(errFraming), .errParity(errParity), .errSummary(errSummary),
    .rtsN(rtsN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bitsOf(input logic [1:0] code);
    return (code == 2'd0) ? 7 : (code == 2'd2) ? 9 : 8;
  endfunction

  task automatic holdBit(input logic b);
    rxIn = b;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  // Sends one frame with the current configuration and checks the result.
  task automatic sendFrame(input logic [8:0] word, input bit badPar,
                           input bit badStop1, input bit badStop2);
    int n;
    logic [8:0] w;
    logic p;
    bit expFr, expPa, expOv;
    n = bitsOf(cfgDataLen);
    w = word & ((9'h1 << n) - 1);
    p = (^w) ^ cfgParityOdd ^ badPar;
    holdBit(1'b0);
    for (int i = 0; i < n; i++) holdBit(w[i]);
    if (cfgParityEn) holdBit(p);
    holdBit(!badStop1);
    if (cfgTwoStop) holdBit(!badStop2);
    rxIn = 1'b1;
    repeat (4) @(negedge clk);
    expOv = expReady;
    expFr = badStop1 || (cfgTwoStop && badStop2);
    expPa = cfgParityEn && badPar;
    expReady = 1'b1;
    check("R6 data", rxData, w);
    check("R1 R7 ready", rxReady, 1);
    check("R9 overrun", errOverrun, expOv);
    check("R10 framing", errFraming, expFr);
    check("R11 parity", errParity, expPa);
    check("R12 summary", errSummary, expOv | expFr | expPa);
    check("R4 rts after start", rtsN, 1);
  endtask

  task automatic readBuf();
    bufRead = 1'b1;
    @(negedge clk);
    bufRead = 1'b0;
    expReady = 1'b0;
    check("R8 ready cleared", rxReady, 0);
    check("R8 rts on read", rtsN, 0);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 reset rts", rtsN, 1);
    check("R2 reset ready", rxReady, 0);
    check("R2 reset data", rxData, 0);
    check("R2 reset flags", {errOverrun, errFraming, errParity, errSummary}, 0);

    rxEnable = 1'b1;
    @(negedge clk);
    check("R3 rts on enable", rtsN, 0);
    repeat (5) @(negedge clk);

    // R5: start pulse shorter than half a bit
    rxIn = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rxIn = 1'b1;
    repeat (3 * BIT_CLK) @(negedge clk);
    check("R5 glitch rts", rtsN, 0);
    check("R5 glitch ready", rxReady, 0);
    check("R5 glitch flags", errSummary, 0);

    // R6, R7: plain 8-bit frame
    sendFrame(9'h0A5, 0, 0, 0);
    readBuf();

    // R9: two words without a read, then a clean one
    sendFrame(9'h03C, 0, 0, 0);
    sendFrame(9'h0C3, 0, 0, 0);
    readBuf();
    sendFrame(9'h011, 0, 0, 0);
    readBuf();

    // R11: 9-bit even parity corrupted, 7-bit odd parity good and bad
    cfgParityEn = 1'b1; cfgDataLen = 2'd2; cfgParityOdd = 1'b0;
    sendFrame(9'h1B7, 1, 0, 0);
    readBuf();
    cfgDataLen = 2'd0; cfgParityOdd = 1'b1;
    sendFrame(9'h05A, 0, 0, 0);
    readBuf();
    sendFrame(9'h05B, 1, 0, 0);
    readBuf();

    // R10: only the second of two stop bits low
    cfgParityEn = 1'b0; cfgDataLen = 2'd3; cfgTwoStop = 1'b1;
    sendFrame(9'h0F0, 0, 0, 1);

    // R2: disable clears flags and lifts rts, R3 re-enable
    rxEnable = 1'b0;
    @(negedge clk);
    check("R2 disabled rts", rtsN, 1);
    check("R2 disabled ready", rxReady, 0);
    check("R2 disabled flags", {errOverrun, errFraming, errParity, errSummary}, 0);
    expReady = 1'b0;
    rxEnable = 1'b1;
    @(negedge clk);
    check("R3 rts re-enable", rtsN, 0);

    // random frames
    for (int k = 0; k < 40; k++) begin
      cfgDataLen   = 2'($urandom_range(0, 3));
      cfgParityEn  = 1'($urandom_range(0, 1));
      cfgParityOdd = 1'($urandom_range(0, 1));
      cfgTwoStop   = 1'($urandom_range(0, 1));
      sendFrame(9'($urandom), ($urandom_range(0, 4) == 0),
                ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0));
      if ($urandom_range(0, 3) != 0) readBuf();
    end

    finishRun();
  end
endmodule